// File: doc/BRIEF.md
# Serial Configuration Loader for a Programmable Device

This block programs a downstream programmable logic device over its slave-serial configuration pins. A start request makes it pull the device's active-low program line low for a fixed minimum time and then release it. It then checks that the device's completion flag (`done_in`) has dropped, and waits out the device's memory-clear latency. After that it pulls bitstream bytes from a valid/ready byte stream and shifts each one out on a divided serial clock and data pair.

The stream is handled in bursts of a fixed length, counted from the first byte of the image. A transfer fault flagged on any byte of a burst is acted on when the last byte of that burst has been shifted out. After the final image byte, the block clocks out all-ones filler bytes while it waits for the completion flag. It sends one more filler byte after the flag rises and then reports success. A completion timeout bounds the wait.

While no sequence runs, a two-bit status output shows whether the device is held in reset or has finished. All time intervals are given in microseconds or nanoseconds, together with a clock-frequency parameter, and are turned into cycle counts at elaboration.

Top module: `fpga_cfg_seq`

## Requirements
- R1: A start request with `start_partial` high, taken while idle, is refused. On the next cycle `err`=1 and `err_code`=1, and `prog_n` stays high with no serial clock activity.
- R2: An accepted start drives `prog_n` low for exactly PULSE_CYC = max(1, ceil(CLK_MHZ*PULSE_NS/1000)) cycles, and `sclk` stays low while `prog_n` is low.
- R3: In the cycle after `prog_n` is released, `done_in` is sampled. If it is high, the sequence ends with `err`=1 and `err_code`=2, and no serial clock edge is produced.
- R4: No rising `sclk` edge occurs within LATENCY_US*CLK_MHZ cycles after `prog_n` is released.
- R5: Each byte is sent MSB first. `sdata` changes only while `sclk` is low. Each clock phase lasts SCLK_HALF cycles, so one byte takes 16*SCLK_HALF cycles.
- R6: Bytes are grouped in bursts of BURST_LEN, counted from the image start. The image's last byte also closes a burst. If `in_err` was high on any byte accepted in a burst, then once that burst's last byte has been shifted, the sequence ends with `err_code`=3. No further stream bytes and no filler bytes are sent.
- R7: If `done_in` is high when the last image byte finishes shifting, exactly one 0xFF byte follows, and then `ok`=1.
- R8: If `done_in` is low at that point, 0xFF bytes are sent back to back. `done_in` is sampled as each one finishes. The first 0xFF that finishes with `done_in` high is followed by exactly one more 0xFF, and then `ok`=1.
- R9: If TIMEOUT_US*CLK_MHZ cycles have passed since the first filler byte started, and a filler byte finishes with `done_in` still low, the sequence ends with `err`=1 and `err_code`=4.
- R10: `dev_status` is 2'b10 while a sequence runs. When idle it is 2'b00 if `done_in` is low and 2'b01 if `done_in` is high.
- R11: While idle, `prog_n` is high, `sclk` is low and `in_ready` is low, and stream input produces no serial activity.
- R12: `ok` and `err` are never high together. They hold their value until the next start request that is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a configuration sequence (taken only when idle) |
| start_partial | input | 1 | Qualifies `start` as a partial-reconfiguration request |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of the image |
| in_err | input | 1 | Transfer fault attached to this byte |
| in_ready | output | 1 | Block accepts a stream byte this cycle |
| done_in | input | 1 | Device completion flag (synchronous to `clk`) |
| prog_n | output | 1 | Active-low program/reset to the device |
| sclk | output | 1 | Serial configuration clock |
| sdata | output | 1 | Serial configuration data |
| busy | output | 1 | A sequence is running |
| ok | output | 1 | Last sequence finished successfully |
| err | output | 1 | Last request or sequence failed |
| err_code | output | 3 | 0 none, 1 partial refused, 2 flag high after pulse, 3 transfer fault, 4 timeout |
| dev_status | output | 2 | 00 device in reset, 01 device finished, 10 sequence running |

## Verification
The hardest case to reach is a completion flag that rises during the filler phase at a chosen byte, since the number of trailing bytes depends on exactly when the flag is sampled. The bench decodes the serial stream at the rising edges of `sclk`. It raises `done_in` from that decoder as soon as a chosen number of bytes has been received, so the flag lands inside a known byte, and it sweeps that point across the last data byte and several filler bytes. Transfer faults are swept over every byte position of a nine-byte image, so that the abort point falls in each burst and on the short final burst.

// File: rtl/cfg_seq_pkg.sv
// Package: shared encodings for the serial configuration loader.
// Assumes: nothing; types only.
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PULSE,
        SQ_CHECK,
        SQ_LATENCY,
        SQ_STREAM,
        SQ_FILL,
        SQ_TAIL
    } seq_state_t;

    localparam logic [2:0] EC_NONE    = 3'd0;
    localparam logic [2:0] EC_PARTIAL = 3'd1;
    localparam logic [2:0] EC_EARLY   = 3'd2;
    localparam logic [2:0] EC_XFER    = 3'd3;
    localparam logic [2:0] EC_TIMEOUT = 3'd4;

    localparam logic [1:0] DS_RESET   = 2'b00;
    localparam logic [1:0] DS_FINISH  = 2'b01;
    localparam logic [1:0] DS_RUNNING = 2'b10;

endpackage

// File: rtl/cfg_timer.sv
// cfg_timer: loadable down-counter that stops at zero.
// Loading value N-1 makes `zero` rise after N cycles; `zero` stays high until the next load.
// Assumes: load and count share clk; synchronous active-low reset clears the count.
module cfg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Count down from the loaded value and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/cfg_shifter.sv
// cfg_shifter: serialises one byte MSB first on a divided clock.
// The clock idles low. Data is placed while the clock is low and changes only after a falling edge.
// Each phase lasts HALF cycles. `fin` pulses for one cycle, with `busy` already low, after the last falling edge.
// Assumes: `load` is honoured only while not busy.
module cfg_shifter #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] byte_in,
    output logic       busy,
    output logic       fin,
    output logic       sclk,
    output logic       sdata
);
    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [DW-1:0] div;
    logic [2:0]    bit_idx;
    logic [7:0]    shreg;

    // Phase divider, bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            busy    <= 1'b0;
            fin     <= 1'b0;
            sclk    <= 1'b0;
            sdata   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (!busy) begin
                if (load) begin
                    shreg   <= byte_in;
                    sdata   <= byte_in[7];
                    busy    <= 1'b1;
                    div     <= DW'(HALF - 1);
                    bit_idx <= '0;
                    sclk    <= 1'b0;
                end
            end else if (div != '0) begin
                div <= div - DW'(1);
            end else begin
                div <= DW'(HALF - 1);
                if (!sclk) begin
                    sclk <= 1'b1;
                end else begin
                    sclk <= 1'b0;
                    if (bit_idx == 3'd7) begin
                        busy <= 1'b0;
                        fin  <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 3'd1;
                        shreg   <= shreg << 1;
                        sdata   <= shreg[6];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fpga_cfg_seq.sv
// fpga_cfg_seq: configuration sequencer for a device with a slave-serial load port.
// Order of work: program pulse, completion-flag check, clear latency, burst streaming,
// all-ones filler bytes until the flag rises, one trailing filler byte, then result.
// Assumes: done_in is already synchronous to clk; intervals are converted to cycles from CLK_MHZ.
module fpga_cfg_seq
    import cfg_seq_pkg::*;
#(
    parameter int CLK_MHZ    = 100,
    parameter int PULSE_NS   = 1000,
    parameter int LATENCY_US = 7500,
    parameter int TIMEOUT_US = 100000,
    parameter int SCLK_HALF  = 2,
    parameter int BURST_LEN  = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_partial,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       in_err,
    output logic       in_ready,
    input  logic       done_in,
    output logic       prog_n,
    output logic       sclk,
    output logic       sdata,
    output logic       busy,
    output logic       ok,
    output logic       err,
    output logic [2:0] err_code,
    output logic [1:0] dev_status
);
    localparam int PULSE_RAW = (CLK_MHZ * PULSE_NS + 999) / 1000;
    localparam int PULSE_CYC = (PULSE_RAW < 1) ? 1 : PULSE_RAW;
    localparam int LAT_CYC   = (CLK_MHZ * LATENCY_US < 1) ? 1 : CLK_MHZ * LATENCY_US;
    localparam int TO_CYC    = (CLK_MHZ * TIMEOUT_US < 1) ? 1 : CLK_MHZ * TIMEOUT_US;
    localparam int MAX_AB    = (PULSE_CYC > LAT_CYC) ? PULSE_CYC : LAT_CYC;
    localparam int TMR_MAX   = (MAX_AB > TO_CYC) ? MAX_AB : TO_CYC;
    localparam int TW        = $clog2(TMR_MAX + 1);
    localparam int BW        = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

    seq_state_t    state;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          sh_load;
    logic [7:0]    sh_byte;
    logic          sh_busy;
    logic          sh_fin;
    logic          accept;
    logic [BW-1:0] burst_cnt;
    logic          burst_bad;
    logic          burst_end;
    logic          img_last;
    logic          close_now;

    cfg_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .value (tmr_val),
        .zero  (tmr_zero)
    );

    cfg_shifter #(.HALF(SCLK_HALF)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .byte_in (sh_byte),
        .busy    (sh_busy),
        .fin     (sh_fin),
        .sclk    (sclk),
        .sdata   (sdata)
    );

    // Stream handshake: one byte per free shifter slot, never in the fin cycle.
    assign in_ready  = (state == SQ_STREAM) && !sh_busy && !sh_fin;
    assign accept    = in_ready && in_valid;
    assign close_now = in_last || (burst_cnt == BW'(BURST_LEN - 1));

    // Per-state requests to the timer and the shifter.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_byte  = 8'hFF;
        case (state)
            SQ_IDLE: if (start && !start_partial) begin
                tmr_load = 1'b1;
                tmr_val  = TW'(PULSE_CYC - 1);
            end
            SQ_CHECK: if (!done_in) begin
                tmr_load = 1'b1;
                tmr_val  = TW'(LAT_CYC - 1);
            end
            SQ_STREAM: begin
                if (accept) begin
                    sh_load = 1'b1;
                    sh_byte = in_data;
                end else if (sh_fin && burst_end && !burst_bad && img_last) begin
                    sh_load = 1'b1;
                    if (!done_in) begin
                        tmr_load = 1'b1;
                        tmr_val  = TW'(TO_CYC - 1);
                    end
                end
            end
            SQ_FILL: if (sh_fin && (done_in || !tmr_zero))
                sh_load = 1'b1;
            default: ;
        endcase
    end

    // Sequence control, burst bookkeeping and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            prog_n    <= 1'b1;
            ok        <= 1'b0;
            err       <= 1'b0;
            err_code  <= EC_NONE;
            burst_cnt <= '0;
            burst_bad <= 1'b0;
            burst_end <= 1'b0;
            img_last  <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: if (start) begin
                    if (start_partial) begin
                        ok       <= 1'b0;
                        err      <= 1'b1;
                        err_code <= EC_PARTIAL;
                    end else begin
                        ok       <= 1'b0;
                        err      <= 1'b0;
                        err_code <= EC_NONE;
                        prog_n   <= 1'b0;
                        state    <= SQ_PULSE;
                    end
                end
                SQ_PULSE: if (tmr_zero) begin
                    prog_n <= 1'b1;
                    state  <= SQ_CHECK;
                end
                SQ_CHECK: begin
                    if (done_in) begin
                        err      <= 1'b1;
                        err_code <= EC_EARLY;
                        state    <= SQ_IDLE;
                    end else begin
                        state <= SQ_LATENCY;
                    end
                end
                SQ_LATENCY: if (tmr_zero) begin
                    burst_cnt <= '0;
                    burst_bad <= 1'b0;
                    burst_end <= 1'b0;
                    img_last  <= 1'b0;
                    state     <= SQ_STREAM;
                end
                SQ_STREAM: begin
                    if (accept) begin
                        burst_bad <= burst_bad | in_err;
                        img_last  <= in_last;
                        burst_end <= close_now;
                        burst_cnt <= close_now ? '0 : burst_cnt + BW'(1);
                    end else if (sh_fin && burst_end) begin
                        burst_end <= 1'b0;
                        if (burst_bad) begin
                            err      <= 1'b1;
                            err_code <= EC_XFER;
                            state    <= SQ_IDLE;
                        end else if (img_last) begin
                            state <= done_in ? SQ_TAIL : SQ_FILL;
                        end
                    end
                end
                SQ_FILL: if (sh_fin) begin
                    if (done_in) begin
                        state <= SQ_TAIL;
                    end else if (tmr_zero) begin
                        err      <= 1'b1;
                        err_code <= EC_TIMEOUT;
                        state    <= SQ_IDLE;
                    end
                end
                SQ_TAIL: if (sh_fin) begin
                    ok    <= 1'b1;
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign busy       = (state != SQ_IDLE);
    assign dev_status = busy ? DS_RUNNING : (done_in ? DS_FINISH : DS_RESET);
endmodule

// File: rtl/fpga_cfg_seq_chk.sv
// fpga_cfg_seq_chk: port-level temporal checks for fpga_cfg_seq, attached by bind.
// Assumes: same clock and synchronous active-low reset as the checked block.
module fpga_cfg_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       start_partial,
    input logic       busy,
    input logic       in_ready,
    input logic       prog_n,
    input logic       sclk,
    input logic       sdata,
    input logic       ok,
    input logic       err,
    input logic [2:0] err_code
);
    // Data holds still through every high clock phase.
    p_sdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));

    // No serial clock while the device is held in program.
    p_quiet_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> !sclk);

    // An accepted full start pulls the program line on the next cycle.
    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !start_partial) |=> (!prog_n && busy));

    // A partial request is refused without touching the device pins.
    p_partial_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && start_partial) |=> (!busy && err && err_code == 3'd1 && prog_n && !sclk));

    // Idle means released program line, quiet clock and no stream intake.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (prog_n && !sclk && !in_ready));

    // Success and failure never coexist.
    p_result_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok && err));
endmodule

bind fpga_cfg_seq fpga_cfg_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_partial (start_partial),
    .busy          (busy),
    .in_ready      (in_ready),
    .prog_n        (prog_n),
    .sclk          (sclk),
    .sdata         (sdata),
    .ok            (ok),
    .err           (err),
    .err_code      (err_code)
);

// File: tb/tb_fpga_cfg_seq.sv
// tb_fpga_cfg_seq: sweeps image lengths, flag-rise points and fault positions on a small configuration.
module tb_fpga_cfg_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MHZ   = 4;
    localparam int PNS   = 1000;
    localparam int LUS   = 5;
    localparam int TUS   = 20;
    localparam int HALF  = 2;
    localparam int BURST = 4;
    localparam int PULSE_CYC = (MHZ * PNS + 999) / 1000;
    localparam int LAT_CYC   = MHZ * LUS;
    localparam int TO_CYC    = MHZ * TUS;
    localparam int BYTE_CYC  = 16 * HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, start_partial = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, done_in, prog_n, sclk, sdata, busy, ok, err;
    logic [2:0] err_code;
    logic [1:0] dev_status;
    logic done_drv = 1'b0;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int cap_n = 0, bit_n = 0, raise_at = -1;
    logic [7:0] acc = 8'h00;
    logic [7:0] cap [0:63];
    int pl_cnt = 0, lat_cnt = 0, sclk_edges = 0;
    logic lat_open = 1'b0, seen_rel = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpga_cfg_seq #(.CLK_MHZ(MHZ), .PULSE_NS(PNS), .LATENCY_US(LUS), .TIMEOUT_US(TUS),
                   .SCLK_HALF(HALF), .BURST_LEN(BURST)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_partial(start_partial),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
        .in_ready(in_ready), .done_in(done_in), .prog_n(prog_n), .sclk(sclk), .sdata(sdata),
        .busy(busy), .ok(ok), .err(err), .err_code(err_code), .dev_status(dev_status));

    assign done_in = done_drv;

    function automatic logic [7:0] pat(int i);
        return 8'hA5 ^ 8'(i * 29 + 3);
    endfunction

    task automatic chk(int act, int exp, string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Serial decoder: capture on rising sclk, raise the flag at a chosen byte count.
    always @(posedge sclk) begin
        acc = {acc[6:0], sdata};
        bit_n++;
        sclk_edges++;
        if (bit_n == 8) begin
            if (cap_n < 64) cap[cap_n] = acc;
            cap_n++;
            bit_n = 0;
            if (cap_n == raise_at) done_drv = 1'b1;
        end
    end

    // Pulse length and release-to-first-clock latency, sampled mid-cycle.
    always @(negedge clk) begin
        cyc++;
        if (!prog_n) pl_cnt++;
        if (!prog_n) begin lat_open = 1'b1; seen_rel = 1'b0; end
        else if (lat_open && !sclk) begin lat_cnt++; seen_rel = 1'b1; end
        else if (lat_open && sclk) lat_open = 1'b0;
    end

    // Watchdog.
    initial begin
        wait (cyc > 150000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic clear_mon(logic dinit, int rat);
        cap_n = 0; bit_n = 0; raise_at = rat; done_drv = dinit;
        pl_cnt = 0; lat_cnt = 0; lat_open = 1'b0; sclk_edges = 0;
    endtask

    task automatic do_start(logic partial);
        @(negedge clk); start = 1'b1; start_partial = partial;
        @(negedge clk); start = 1'b0; start_partial = 1'b0;
    endtask

    task automatic feed(int n, int bad_idx);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = pat(i); in_last = (i == n - 1); in_err = (i == bad_idx);
            while (!in_ready && busy) @(negedge clk);
            if (!busy) break;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 20000) begin @(negedge clk); g++; end
        @(negedge clk);
    endtask

    task automatic run_image(int n, int bad_idx, int rat, int exp_ff, logic [2:0] exp_code);
        int exp_bytes;
        clear_mon(1'b0, rat);
        do_start(1'b0);
        chk(int'(dev_status), 2, "R10 running status");
        feed(n, bad_idx);
        wait_idle();
        exp_bytes = n + exp_ff;
        if (bad_idx >= 0) exp_bytes = ((bad_idx / BURST + 1) * BURST < n) ? (bad_idx / BURST + 1) * BURST : n;
        chk(pl_cnt, PULSE_CYC, "R2 pulse length");
        chk(int'(lat_cnt >= LAT_CYC), 1, "R4 latency before first clock");
        chk(cap_n, exp_bytes, (bad_idx >= 0) ? "R6 bytes before abort" : "R8 byte total");
        for (int i = 0; i < exp_bytes && i < 64; i++)
            chk(int'(cap[i]), int'((i < n) ? pat(i) : 8'hFF), "R5 byte content msb first");
        chk(int'(err_code), int'(exp_code), "R9 R6 result code");
        chk(int'(ok), int'(exp_code == 3'd0), "R7 ok flag");
        chk(int'(ok && err), 0, "R12 exclusive result");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // Reset state.
        chk(int'(prog_n), 1, "R11 reset prog_n");
        chk(int'(sclk), 0, "R11 reset sclk");
        chk(int'(in_ready), 0, "R11 reset in_ready");
        chk(int'(ok) + int'(err), 0, "R12 reset results");
        chk(int'(dev_status), 0, "R10 reset status");
        rst_n = 1'b1;
        @(negedge clk);

        // Idle: status follows flag; stream ignored.
        clear_mon(1'b1, -1);
        @(negedge clk);
        chk(int'(dev_status), 1, "R10 idle finished status");
        in_valid = 1'b1; in_data = 8'h00; in_last = 1'b1;
        repeat (40) @(negedge clk);
        chk(int'(in_ready), 0, "R11 idle in_ready");
        chk(sclk_edges, 0, "R11 idle no clock");
        in_valid = 1'b0; in_last = 1'b0;
        done_drv = 1'b0;
        @(negedge clk);
        chk(int'(dev_status), 0, "R10 idle reset status");

        // Partial request refused.
        clear_mon(1'b0, -1);
        do_start(1'b1);
        chk(int'(err), 1, "R1 partial err");
        chk(int'(err_code), 1, "R1 partial code");
        repeat (30) @(negedge clk);
        chk(pl_cnt, 0, "R1 prog_n untouched");
        chk(sclk_edges, 0, "R1 no clock");
        chk(int'(busy), 0, "R1 stays idle");

        // Flag high right after the pulse.
        clear_mon(1'b1, -1);
        do_start(1'b0);
        wait_idle();
        chk(pl_cnt, PULSE_CYC, "R2 pulse length early flag");
        chk(int'(err_code), 2, "R3 early flag code");
        chk(int'(err), 1, "R3 early flag err");
        chk(sclk_edges, 0, "R3 no clock");
        done_drv = 1'b0;

        // Success paths: flag rises inside byte n+k, trailing filler count k+1.
        for (int ni = 0; ni < 5; ni++) begin
            int n;
            n = (ni == 0) ? 1 : (ni == 1) ? 4 : (ni == 2) ? 5 : (ni == 3) ? 8 : 9;
            for (int k = 0; k < 3; k++) begin
                run_image(n, -1, n + k, k + 1, 3'd0);
                chk(int'(ok), 1, (k == 0) ? "R7 single tail byte" : "R8 flag seen in filler");
                chk(int'(dev_status), 1, "R10 status after success");
            end
        end

        // Transfer faults at every byte of a nine-byte image.
        for (int b = 0; b < 9; b++) begin
            run_image(9, b, -1, 0, 3'd3);
            chk(int'(err), 1, "R6 fault err");
        end

        // Completion timeout.
        run_image(2, -1, -1, (TO_CYC + BYTE_CYC) / (BYTE_CYC + 1), 3'd4);
        chk(int'(err), 1, "R9 timeout err");
        chk(int'(dev_status), 0, "R10 status after timeout");

        // A new start clears the previous result.
        clear_mon(1'b0, -1);
        do_start(1'b0);
        chk(int'(err) + int'(ok), 0, "R12 cleared on start");
        feed(1, -1);
        wait_idle();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule